// File: doc/BRIEF.md
# Parallel Printer Host Port Controller

This block lets a CPU with a 16-bit data bus drive a unidirectional, byte-wide printer port through three even I/O addresses. Only the low byte of the bus carries data. Software writes a character into the data register. A hardware sequencer then puts the byte on the printer lines, waits out the data setup time, and drives a timed active-low strobe. It keeps the data steady for the hold time and then waits for the printer's acknowledge pulse. A second register drives the printer control lines. A third register, read-only, reports the printer status lines after synchronization, together with three sequencer flags.

The sequencer counts every timing interval in clock cycles. The count is derived from a clock-frequency parameter and rounded up, so that no interval is shorter than 0.5 us. The printer's busy and acknowledge lines pass through two-flop synchronizers. A strobe is never started while busy is high. A byte written while a transfer is still running is dropped and recorded in a sticky flag. The sequencer also gives up waiting for the acknowledge after a configurable number of cycles, so it cannot stall forever.

Top module: `prn_host_if`

## Requirements
- R1: Full address compare: a write to 38h starts a transfer, 3Ah reads status, and 3Ch writes the control register. A write to any other address changes no output. A read of any address other than 3Ah returns zero.
- R2: Only bus bits 7..0 carry data. Write bits 15..8 are ignored, and read bits 15..8 are always zero.
- R3: Status read data appears one cycle after the read strobe. Its layout is: bit7 busy, bit6 acknowledge (active low), bit5 paper-out, bit4 selected, bit3 error (active low), bit2 transfer active, bit1 sticky timeout, bit0 sticky overrun. The five line bits are the printer inputs after two synchronizing flops.
- R4: After a data write in idle, `lpt_data` carries the new byte for N cycles before `lpt_strobe_n` falls. N = ceil(CLK_KHZ*MIN_NS/1e6), which is 5 for the bench's 10 MHz setting.
- R5: The hardware strobe stays low for exactly N cycles.
- R6: After the strobe rises, data stays unchanged for at least N cycles before another transfer can start.
- R7: The strobe does not fall while synchronized busy is high. The setup phase is extended until busy is low.
- R8: A falling edge on the synchronized acknowledge returns the sequencer to idle, and the next data write is then accepted.
- R9: A data write while a transfer is active is ignored: `lpt_data` stays the same and no new strobe follows. Status bit0 is set and stays set until the next status read, which clears it.
- R10: If no acknowledge arrives within TIMEOUT_CYC cycles of waiting, the sequencer returns to idle and status bit1 is set, cleared on the next status read.
- R11: Control bits: bit0 software strobe (low forces `lpt_strobe_n` low), bit1 auto-feed (active low), bit2 init (active low), bit3 select-in (active low), bit4 interrupt enable, bit5 bidirectional enable. Bits 7..6 are ignored.
- R12: After reset, `lpt_data` is 0, all four active-low control pins are high, both enables are 0, and the sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O byte address |
| io_wdata | input | 16 | Write data bus |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_rdata | output | 16 | Registered read data |
| lpt_data | output | 8 | Printer data lines |
| lpt_strobe_n | output | 1 | Printer strobe, active low |
| lpt_autofd_n | output | 1 | Auto line feed, active low |
| lpt_init_n | output | 1 | Printer init, active low |
| lpt_selin_n | output | 1 | Select-in, active low |
| lpt_irq_en | output | 1 | Interrupt enable control bit |
| lpt_bidir_en | output | 1 | Bidirectional enable control bit |
| lpt_busy | input | 1 | Printer busy |
| lpt_ack_n | input | 1 | Printer acknowledge, active low |
| lpt_paper_out | input | 1 | Paper-out status |
| lpt_select | input | 1 | Printer selected |
| lpt_error_n | input | 1 | Printer error, active low |

## Verification
The bench sweeps many data bytes through full handshakes and counts setup, strobe and hold cycles at the pins. A design whose counters were off by one would show a setup or pulse length of N-1 or N+1. It holds busy high across a write: a design that ignored busy would fire the strobe early. It writes during a strobe, which would corrupt the printer data or start a second pulse in a design without the idle check. The bench also lets the acknowledge never arrive, which would hang a design without the timeout. All 32 status line combinations are swept to catch bit-order mistakes. Near-miss addresses catch a design that compares too few address bits.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SETUP  = 3'd1,
    SQ_STROBE = 3'd2,
    SQ_HOLD   = 3'd3,
    SQ_WAIT   = 3'd4
  } seq_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LINE_N = 5; // busy, ack_n, paper_out, select, error_n
endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/prn_strobe_seq.sv
module prn_strobe_seq
  import prn_pkg::*;
#(
  parameter int unsigned STEP_CYC    = 25,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [BYTE_W-1:0] go_byte,
  input  logic              busy_s,
  input  logic              ack_n_s,
  output logic [BYTE_W-1:0] data_q,
  output logic              strobe_n_q,
  output logic              active,
  output logic              ovr_pulse,
  output logic              to_pulse
);
  localparam int unsigned CNT_W = $clog2(STEP_CYC + 1);
  localparam int unsigned TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CYC - 1);
  localparam logic [CNT_W-1:0] STEP_FULL = CNT_W'(STEP_CYC);
  localparam logic [TO_W-1:0]  TO_LAST   = TO_W'(TIMEOUT_CYC - 1);

  seq_state_e        state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic [TO_W-1:0]   tcnt;
  logic              ack_prev, ack_fell, ack_seen;
  logic              step_done, to_hit;

  assign ack_fell  = ack_prev & ~ack_n_s;
  assign step_done = (cnt == STEP_LAST);
  assign to_hit    = (tcnt == TO_LAST);
  assign active    = (state != SQ_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE:   if (go) nxt = SQ_SETUP;
      SQ_SETUP:  if (step_done && !busy_s) nxt = SQ_STROBE;
      SQ_STROBE: if (step_done) nxt = SQ_HOLD;
      SQ_HOLD:   if (step_done) nxt = SQ_WAIT;
      SQ_WAIT:   if (ack_seen || ack_fell || to_hit) nxt = SQ_IDLE;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      cnt        <= '0;
      tcnt       <= '0;
      data_q     <= '0;
      strobe_n_q <= 1'b1;
      ovr_pulse  <= 1'b0;
      to_pulse   <= 1'b0;
      ack_prev   <= 1'b1;
      ack_seen   <= 1'b0;
    end else begin
      ack_prev   <= ack_n_s;
      ovr_pulse  <= go && (state != SQ_IDLE);
      to_pulse   <= (state == SQ_WAIT) && to_hit && !ack_seen && !ack_fell;
      strobe_n_q <= (nxt != SQ_STROBE);
      if (nxt != state)   cnt <= '0;
      else if (!step_done) cnt <= cnt + 1'b1;
      if (state != SQ_WAIT) tcnt <= '0;
      else if (!to_hit)     tcnt <= tcnt + 1'b1;
      if (state == SQ_IDLE) ack_seen <= 1'b0;
      else if (ack_fell)    ack_seen <= 1'b1;
      if (state == SQ_IDLE && go) data_q <= go_byte;
      state <= nxt;
    end
  end

  // Checker counters: data age, cycles since strobe rise, strobe low length
  logic [CNT_W-1:0] data_age, since_rise, low_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_age   <= STEP_FULL;
      since_rise <= STEP_FULL;
      low_len    <= '0;
    end else begin
      if (state == SQ_IDLE && go)   data_age <= '0;
      else if (data_age != STEP_FULL) data_age <= data_age + 1'b1;
      if (!strobe_n_q && nxt != SQ_STROBE) since_rise <= '0;
      else if (since_rise != STEP_FULL)    since_rise <= since_rise + 1'b1;
      if (nxt == SQ_STROBE) low_len <= strobe_n_q ? CNT_W'(1) : low_len + 1'b1;
    end
  end

  AST_SETUP_TIME: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_n_q) |-> data_age >= STEP_FULL); // R4
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_n_q) |-> low_len == STEP_FULL); // R5
  AST_HOLD_TIME: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && go) |-> since_rise >= STEP_FULL); // R6
  AST_NO_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_n_q) |-> !$past(busy_s)); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(data_q)); // R9
endmodule

// File: rtl/prn_regfile.sv
module prn_regfile
  import prn_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BUS_W      = 16,
  parameter logic [ADDR_W-1:0] A_DATA = ADDR_W'('h38),
  parameter logic [ADDR_W-1:0] A_STAT = ADDR_W'('h3A),
  parameter logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h3C)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic [LINE_N-1:0] lines_s,
  input  logic              seq_active,
  input  logic              ovr_pulse,
  input  logic              to_pulse,
  output logic              data_go,
  output logic [BYTE_W-1:0] data_byte,
  output logic [5:0]        ctrl_q,
  output logic [BUS_W-1:0]  rdata
);
  logic              sts_ovr, sts_to, stat_rd;
  logic [BYTE_W-1:0] stat_byte;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[BUS_W-1:BYTE_W];
  assign data_go   = wr && (addr == A_DATA);
  assign data_byte = wdata[BYTE_W-1:0];
  assign stat_rd   = rd && (addr == A_STAT);
  assign stat_byte = {lines_s, seq_active, sts_to, sts_ovr};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 6'b00_1111;
      sts_ovr <= 1'b0;
      sts_to  <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr && addr == A_CTRL) ctrl_q <= wdata[5:0];
      sts_ovr <= (sts_ovr & ~stat_rd) | ovr_pulse;
      sts_to  <= (sts_to & ~stat_rd) | to_pulse;
      rdata   <= stat_rd ? {{(BUS_W-BYTE_W){1'b0}}, stat_byte} : '0;
    end
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr_pulse |=> sts_ovr); // R9
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (rst)
    to_pulse |=> sts_to); // R10
endmodule

// File: rtl/prn_host_if.sv
module prn_host_if
  import prn_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CLK_KHZ     = 50000,
  parameter int unsigned MIN_NS      = 500,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [15:0]       io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [15:0]       io_rdata,
  output logic [7:0]        lpt_data,
  output logic              lpt_strobe_n,
  output logic              lpt_autofd_n,
  output logic              lpt_init_n,
  output logic              lpt_selin_n,
  output logic              lpt_irq_en,
  output logic              lpt_bidir_en,
  input  logic              lpt_busy,
  input  logic              lpt_ack_n,
  input  logic              lpt_paper_out,
  input  logic              lpt_select,
  input  logic              lpt_error_n
);
  localparam int unsigned RAW_CYC  = (CLK_KHZ * MIN_NS + 999_999) / 1_000_000;
  localparam int unsigned STEP_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  logic [LINE_N-1:0] lines_s;
  logic              data_go, seq_active, ovr_pulse, to_pulse, hw_strobe_n;
  logic [7:0]        data_byte;
  logic [5:0]        ctrl_q;

  prn_sync #(.W(LINE_N), .RST_VAL(5'b01011)) u_sync (
    .clk(clk), .rst(rst),
    .d({lpt_busy, lpt_ack_n, lpt_paper_out, lpt_select, lpt_error_n}),
    .q(lines_s)
  );

  prn_regfile #(.ADDR_W(ADDR_W), .BUS_W(16)) u_regs (
    .clk(clk), .rst(rst), .addr(io_addr), .wdata(io_wdata), .wr(io_wr), .rd(io_rd),
    .lines_s(lines_s), .seq_active(seq_active), .ovr_pulse(ovr_pulse), .to_pulse(to_pulse),
    .data_go(data_go), .data_byte(data_byte), .ctrl_q(ctrl_q), .rdata(io_rdata)
  );

  prn_strobe_seq #(.STEP_CYC(STEP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .rst(rst), .go(data_go), .go_byte(data_byte),
    .busy_s(lines_s[4]), .ack_n_s(lines_s[3]),
    .data_q(lpt_data), .strobe_n_q(hw_strobe_n), .active(seq_active),
    .ovr_pulse(ovr_pulse), .to_pulse(to_pulse)
  );

  assign lpt_strobe_n = hw_strobe_n & ctrl_q[0];
  assign lpt_autofd_n = ctrl_q[1];
  assign lpt_init_n   = ctrl_q[2];
  assign lpt_selin_n  = ctrl_q[3];
  assign lpt_irq_en   = ctrl_q[4];
  assign lpt_bidir_en = ctrl_q[5];
endmodule

// File: tb/prn_host_if_bench.sv
module prn_host_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 10000;
  localparam int TMO        = 40;
  localparam int N          = (CLK_KHZ * 500 + 999_999) / 1_000_000;

  logic clk = 0, rst = 1;
  logic [7:0] io_addr = 0;
  logic [15:0] io_wdata = 0, io_rdata;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] lpt_data;
  logic lpt_strobe_n, lpt_autofd_n, lpt_init_n, lpt_selin_n, lpt_irq_en, lpt_bidir_en;
  logic lpt_busy = 0, lpt_ack_n = 1, lpt_paper_out = 0, lpt_select = 1, lpt_error_n = 1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prn_host_if #(.ADDR_W(8), .CLK_KHZ(CLK_KHZ), .MIN_NS(500), .TIMEOUT_CYC(TMO)) u_prn_host_if (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .lpt_data(lpt_data), .lpt_strobe_n(lpt_strobe_n),
    .lpt_autofd_n(lpt_autofd_n), .lpt_init_n(lpt_init_n), .lpt_selin_n(lpt_selin_n),
    .lpt_irq_en(lpt_irq_en), .lpt_bidir_en(lpt_bidir_en), .lpt_busy(lpt_busy),
    .lpt_ack_n(lpt_ack_n), .lpt_paper_out(lpt_paper_out), .lpt_select(lpt_select),
    .lpt_error_n(lpt_error_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] idle_status();
    return {lpt_busy, lpt_ack_n, lpt_paper_out, lpt_select, lpt_error_n, 3'b000};
  endfunction

  task automatic ack_pulse();
    lpt_ack_n = 0; idle_cycles(3); lpt_ack_n = 1; idle_cycles(4);
  endtask

  // Write byte, measure setup and strobe width at the pins, then check hold.
  task automatic transfer(input logic [7:0] b, input logic [7:0] hi);
    int su, wd;
    logic [15:0] r;
    io_write(8'h38, {hi, b});
    su = 0;
    while (lpt_strobe_n && su < 100) begin
      chk(lpt_data == b, "R4 data during setup", lpt_data, b);
      su++; @(negedge clk);
    end
    chk(su == N, "R4 setup cycles", su, N);
    wd = 0;
    while (!lpt_strobe_n && wd < 100) begin
      wd++; @(negedge clk);
    end
    chk(wd == N, "R5 strobe width", wd, N);
    for (int i = 0; i < N; i++) begin
      chk(lpt_strobe_n && lpt_data == b, "R6 hold data", lpt_data, b);
      @(negedge clk);
    end
    ack_pulse();
    io_read(8'h3A, r);
    chk(r == {8'h00, idle_status()}, "R8 idle after ack", r, idle_status());
  endtask

  initial begin
    logic [15:0] r;
    int cnt;
    logic [7:0] exp;
    idle_cycles(3);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk({lpt_data, lpt_strobe_n, lpt_autofd_n, lpt_init_n, lpt_selin_n, lpt_irq_en, lpt_bidir_en}
        == {8'h00, 6'b111100}, "R12 reset pins",
        {lpt_data, lpt_strobe_n, lpt_autofd_n, lpt_init_n, lpt_selin_n, lpt_irq_en, lpt_bidir_en},
        14'b00000000111100);
    idle_cycles(3);
    io_read(8'h3A, r);
    chk(r == 16'h0058, "R12 reset status", r, 16'h0058);

    // R3 status sweep over all five line combinations
    for (int v = 0; v < 32; v++) begin
      {lpt_busy, lpt_ack_n, lpt_paper_out, lpt_select, lpt_error_n} = v[4:0];
      idle_cycles(3);
      io_read(8'h3A, r);
      exp = 8'(v << 3);
      chk(r == {8'h00, exp}, "R3 status layout", r, exp);
    end
    {lpt_busy, lpt_ack_n, lpt_paper_out, lpt_select, lpt_error_n} = 5'b01011;
    idle_cycles(4);

    // R11 control bits, R2 upper byte ignored
    io_write(8'h3C, 16'hFF35);
    @(negedge clk);
    chk({lpt_bidir_en, lpt_irq_en, lpt_selin_n, lpt_init_n, lpt_autofd_n, lpt_strobe_n} == 6'b110101,
        "R11 control pins", {lpt_bidir_en, lpt_irq_en, lpt_selin_n, lpt_init_n, lpt_autofd_n, lpt_strobe_n}, 6'h35);
    io_write(8'h3C, 16'h00CE);
    chk(lpt_strobe_n == 0 && lpt_autofd_n == 1, "R11 software strobe", lpt_strobe_n, 0);
    io_write(8'h3C, 16'h000F);
    chk(lpt_strobe_n == 1 && lpt_irq_en == 0 && lpt_bidir_en == 0, "R11 restore", lpt_strobe_n, 1);

    // R1 near-miss addresses have no effect
    io_write(8'h3D, 16'h0030);
    io_write(8'h39, 16'h00AA);
    io_write(8'hB8, 16'h00AA);
    cnt = 0;
    for (int i = 0; i < 2 * N + 4; i++) begin
      if (!lpt_strobe_n || lpt_data != 0 || lpt_irq_en || lpt_bidir_en) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R1 stray write", cnt, 0);
    io_read(8'h38, r);
    chk(r == 0, "R1 read data addr", r, 0);
    io_read(8'h3B, r);
    chk(r == 0, "R1 read other addr", r, 0);

    // R4 R5 R6 R8 R2 transfer sweep
    for (int k = 0; k < 24; k++) transfer(8'((k * 37) ^ 8'hA5), 8'(~k));

    // R7 busy holds off the strobe
    lpt_busy = 1; idle_cycles(3);
    io_write(8'h38, 16'h005A);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (!lpt_strobe_n) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R7 no strobe while busy", cnt, 0);
    lpt_busy = 0;
    cnt = 0;
    while (lpt_strobe_n && cnt < 50) begin cnt++; @(negedge clk); end
    chk(cnt >= 2 && cnt <= 4, "R7 strobe after busy drop", cnt, 3);
    cnt = 0;
    while (!lpt_strobe_n && cnt < 50) begin cnt++; @(negedge clk); end
    chk(cnt == N, "R7 R5 width after busy", cnt, N);
    idle_cycles(N); ack_pulse();

    // R9 overrun during strobe
    io_write(8'h38, 16'h0011);
    while (lpt_strobe_n) @(negedge clk);
    io_write(8'h38, 16'h0099);
    chk(lpt_data == 8'h11, "R9 data unchanged", lpt_data, 8'h11);
    idle_cycles(2 * N); ack_pulse();
    cnt = 0;
    for (int i = 0; i < 2 * N + 2; i++) begin
      if (!lpt_strobe_n) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R9 no extra strobe", cnt, 0);
    io_read(8'h3A, r);
    chk(r == 16'h0059, "R9 overrun flag set", r, 16'h0059);
    io_read(8'h3A, r);
    chk(r == 16'h0058, "R9 overrun flag cleared", r, 16'h0058);
    transfer(8'h3C, 8'h00); // R8 next write accepted

    // R10 timeout
    io_write(8'h38, 16'h0077);
    idle_cycles(3 * N + 10);
    io_read(8'h3A, r);
    chk(r == 16'h005C, "R10 still waiting", r, 16'h005C);
    idle_cycles(TMO + 5);
    io_read(8'h3A, r);
    chk(r == 16'h005A, "R10 timeout flag", r, 16'h005A);
    io_read(8'h3A, r);
    chk(r == 16'h0058, "R10 flag cleared", r, 16'h0058);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule